// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block connects a CPU core to a 16-bit external memory bus on which every address names one byte of a 20-bit space. The core hands it one request at a time: an address, a size flag (byte or word), a direction flag and write data. The block places each byte on the bus half that its address parity selects. It drives the two byte enables to match. A word at an odd address is broken into two byte cycles. On reads, the block puts the result back together in little-endian order and returns it with a single-cycle done pulse.

The request side uses a valid/ready handshake. The memory side holds a request strobe, address, byte enables, direction and write data steady until the memory answers with ready. The first bus cycle starts the clock after a request is accepted. The block takes no new request until the done pulse for the current one appears.

Top module: `bytelane_seq`

## Requirements
- R1: While reset is active and after it is released, `req_ready` is 1, `mem_req` is 0 and `done` is 0 until a request is accepted.
- R2: A byte access at an even address runs one bus cycle at that address with `mem_be` = 2'b01, and on a write the byte from `req_wdata[7:0]` travels on `mem_wdata[7:0]`.
- R3: A byte access at an odd address runs one bus cycle at that address with `mem_be` = 2'b10, and on a write the byte from `req_wdata[7:0]` travels on `mem_wdata[15:8]`.
- R4: A word access at an even address runs one bus cycle with `mem_be` = 2'b11. `req_wdata` appears unchanged on `mem_wdata`, and a read returns `mem_rdata` unchanged.
- R5: A word access at odd address A runs two bus cycles. The first is at A with `mem_be` = 2'b10 and carries `req_wdata[7:0]` on `mem_wdata[15:8]`. The second is at A+1 with `mem_be` = 2'b01 and carries `req_wdata[15:8]` on `mem_wdata[7:0]`.
- R6: The second cycle of a split word computes A+1 modulo 2^20, so address 20'hFFFFF is followed by 20'h00000.
- R7: A byte read returns the addressed lane's byte in `rdata[7:0]` with `rdata[15:8]` = 0, for both lanes.
- R8: A split word read returns {byte from `mem_rdata[7:0]` of the second cycle, byte from `mem_rdata[15:8]` of the first cycle}.
- R9: While `mem_req` is 1 and `mem_ready` is 0, `mem_addr`, `mem_be`, `mem_wr` and `mem_wdata` hold their values into the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the final bus cycle's ready. `req_ready` is 0 from the cycle after acceptance until that cycle.
- R11: A write completes with `rdata` = 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 20 | Byte address of the request |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| mem_req | output | 1 | Bus cycle requested |
| mem_addr | output | 20 | Bus byte address |
| mem_be | output | 2 | Byte enables, bit 0 = lane 7..0, bit 1 = lane 15..8 |
| mem_wr | output | 1 | Bus cycle is a write |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data |
| mem_ready | input | 1 | Memory completes the current bus cycle |

## Verification
The bench covers odd-address word accesses in both directions. A design that swapped the lane order or the byte order would write the wrong byte to A and A+1, and it would return the halves reversed. It runs a word access at the top of the address space. A design that carried out of 20 bits, or that left A unchanged, would hit the wrong byte on the second cycle. Byte reads come from both lanes, which catches a design that forgets to shift the upper byte down or that leaves the other lane's byte in bits 15..8. The memory model adds varied wait states, so a design that drops its outputs during a wait, or that pulses done early or for two cycles, disagrees with the bus and result queues.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int BUS_W  = LANES * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } bls_state_e;
endpackage

// File: rtl/bls_rst_sync.sv
module bls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bls_lane_plan.sv
module bls_lane_plan
  import bls_pkg::*;
(
  input  logic             odd,
  input  logic             word,
  input  logic             second,
  input  logic [BUS_W-1:0] wdata,
  output logic [LANES-1:0] be,
  output logic [BUS_W-1:0] lane_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic             en;
    logic [LANE_W-1:0] src;

    always_comb begin
      if (word && !odd) begin
        en  = 1'b1;
        src = wdata[g*LANE_W +: LANE_W];
      end else if (word) begin
        en  = second ? (g == 0) : (g == LANES-1);
        src = second ? wdata[BUS_W-1 -: LANE_W] : wdata[LANE_W-1:0];
      end else begin
        en  = (odd == (g == LANES-1));
        src = wdata[LANE_W-1:0];
      end
    end

    assign be[g] = en;
    assign lane_data[g*LANE_W +: LANE_W] = en ? src : '0;
  end
endmodule

// File: rtl/bls_gather.sv
module bls_gather
  import bls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_lo,
  input  logic             finish,
  input  logic             word,
  input  logic             odd,
  input  logic             write,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic             done,
  output logic [BUS_W-1:0] rdata
);
  logic [LANE_W-1:0] lo_q;
  logic [BUS_W-1:0]  rdata_q;
  logic [BUS_W-1:0]  result_d;
  logic              done_q;

  always_comb begin
    if (write)
      result_d = '0;
    else if (!word)
      result_d = {{(BUS_W-LANE_W){1'b0}},
                  odd ? bus_rdata[BUS_W-1 -: LANE_W] : bus_rdata[LANE_W-1:0]};
    else if (!odd)
      result_d = bus_rdata;
    else
      result_d = {bus_rdata[LANE_W-1:0], lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (capture_lo) lo_q <= bus_rdata[BUS_W-1 -: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (finish) rdata_q <= result_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign done  = done_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/bytelane_seq.sv
module bytelane_seq
  import bls_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              done,
  output logic [BUS_W-1:0]  rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic              mem_wr,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              mem_ready
);
  logic rst_sync_n;

  bls_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bls_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q, write_q;
  logic [BUS_W-1:0]  wdata_q;
  logic              accept, split, second;
  logic              capture_lo, finish;
  logic [ADDR_W-1:0] addr_next;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign split     = word_q && addr_q[0];
  assign second    = (state_q == ST_SECOND);
  assign addr_next = addr_q + ADDR_W'(1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_FIRST;
      ST_FIRST:  if (mem_ready) state_d = split ? ST_SECOND : ST_IDLE;
      ST_SECOND: if (mem_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      word_q  <= req_word;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  assign capture_lo = (state_q == ST_FIRST) && mem_ready && split;
  assign finish     = mem_ready && (second || ((state_q == ST_FIRST) && !split));

  bls_lane_plan u_plan (
    .odd       (addr_q[0]),
    .word      (word_q),
    .second    (second),
    .wdata     (wdata_q),
    .be        (mem_be),
    .lane_data (mem_wdata)
  );

  bls_gather u_gather (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .capture_lo (capture_lo),
    .finish     (finish),
    .word       (word_q),
    .odd        (addr_q[0]),
    .write      (write_q),
    .bus_rdata  (mem_rdata),
    .done       (done),
    .rdata      (rdata)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_addr  = second ? addr_next : addr_q;
  assign mem_wr    = write_q;
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic              mem_wr,
  input logic [15:0]       mem_wdata,
  input logic              mem_ready
);
  a_r1_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  a_r2_some_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 2'b00));

  a_r5_second_half_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req && mem_ready && (mem_be == 2'b10)))
      |-> (mem_be == 2'b01) && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r9_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                  && $stable(mem_wr) && $stable(mem_wdata)));

  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ready));
endmodule

bind bytelane_seq bls_checker #(.ADDR_W(ADDR_W)) u_bls_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/bytelane_seq_test.sv
module bytelane_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_word, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic          done;
  logic [15:0]   rdata;
  logic          mem_req, mem_wr, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelane_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    be;
    logic          wr;
    logic [15:0]   wdata;
    string         tag;
  } bus_item_t;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } res_item_t;

  bus_item_t bus_q[$];
  res_item_t res_q[$];
  logic [7:0] mem [int];

  function automatic logic [7:0] rd_byte(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ {4'h6, a[19:16]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory model, bus scoreboard and result monitor, all at the falling edge
  int          wait_left = 0;
  int          xfer_cnt  = 0;
  bit          was_wait  = 0;
  bit          prev_done = 0;
  logic [AW-1:0] held_addr;
  logic [1:0]  held_be;
  logic [15:0] held_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (was_wait) begin
        chk(mem_req && mem_addr == held_addr && mem_be == held_be && mem_wdata == held_wdata,
            "R9", "bus held during wait", {mem_be, 10'b0, mem_addr}, {held_be, 10'b0, held_addr});
      end
      if (mem_req) begin
        if (wait_left > 0) begin
          wait_left--;
          mem_ready = 1'b0;
          was_wait  = 1'b1;
          held_addr = mem_addr; held_be = mem_be; held_wdata = mem_wdata;
        end else begin
          logic [AW-1:0] a0, a1;
          bus_item_t     e;
          mem_ready = 1'b1;
          was_wait  = 1'b0;
          a0 = {mem_addr[AW-1:1], 1'b0};
          a1 = {mem_addr[AW-1:1], 1'b1};
          if (bus_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected bus cycle", {12'b0, mem_addr}, 32'h0);
          end else begin
            logic [15:0] m;
            e = bus_q.pop_front();
            m = {{8{e.be[1]}}, {8{e.be[0]}}};
            chk(mem_addr == e.addr, e.tag, "bus address", {12'b0, mem_addr}, {12'b0, e.addr});
            chk(mem_be == e.be, e.tag, "byte enables", {30'b0, mem_be}, {30'b0, e.be});
            chk(mem_wr == e.wr, e.tag, "direction", {31'b0, mem_wr}, {31'b0, e.wr});
            if (e.wr)
              chk((mem_wdata & m) == (e.wdata & m), e.tag, "write lanes",
                  {16'b0, mem_wdata & m}, {16'b0, e.wdata & m});
          end
          mem_rdata = {rd_byte(a1), rd_byte(a0)};
          if (mem_wr && mem_be[0]) mem[int'(a0)] = mem_wdata[7:0];
          if (mem_wr && mem_be[1]) mem[int'(a1)] = mem_wdata[15:8];
          xfer_cnt++;
          wait_left = (xfer_cnt * 3) % 4;
        end
      end else begin
        mem_ready = 1'b0;
        was_wait  = 1'b0;
      end
      if (prev_done)
        chk(!done, "R10", "done width", {31'b0, done}, 32'h0);
      if (done) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
        end else begin
          res_item_t r;
          r = res_q.pop_front();
          chk(rdata == r.val, r.tag, "result", {16'b0, rdata}, {16'b0, r.val});
        end
      end
      prev_done = done;
    end
  end

  // Driver: pushes expected bus cycles and result, then issues the request
  task automatic issue(logic [AW-1:0] a, bit word, bit wr, logic [15:0] wd,
                       string btag, string rtag);
    logic [AW-1:0] a1;
    logic [15:0]   res;
    a1 = a + 1'b1;
    if (!word) begin
      bus_q.push_back('{a, a[0] ? 2'b10 : 2'b01, wr,
                        a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]}, btag});
      res = {8'h00, rd_byte(a)};
    end else if (!a[0]) begin
      bus_q.push_back('{a, 2'b11, wr, wd, btag});
      res = {rd_byte(a1), rd_byte(a)};
    end else begin
      bus_q.push_back('{a, 2'b10, wr, {wd[7:0], 8'h00}, btag});
      bus_q.push_back('{a1, 2'b01, wr, {8'h00, wd[15:8]}, btag});
      res = {rd_byte(a1), rd_byte(a)};
    end
    if (wr) res_q.push_back('{16'h0000, "R11"});
    else    res_q.push_back('{res, rtag});
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = word; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "busy after accept", {31'b0, req_ready}, 32'h0);
    while (res_q.size() != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0; mem_ready = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done, "R1", "in reset",
        {29'b0, req_ready, mem_req, done}, 32'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_req && !done, "R1", "after reset",
        {29'b0, req_ready, mem_req, done}, 32'h4);

    issue(20'h00010, 0, 1, 16'h77A5, "R2", "R2");
    issue(20'h00011, 0, 1, 16'h335A, "R3", "R3");
    issue(20'h00020, 1, 1, 16'h1234, "R4", "R4");
    issue(20'h00031, 1, 1, 16'hBEEF, "R5", "R5");
    issue(20'hFFFFF, 1, 1, 16'hC0DE, "R6", "R6");
    issue(20'h00010, 0, 0, 16'h0,    "R2", "R7");
    issue(20'h00011, 0, 0, 16'h0,    "R3", "R7");
    issue(20'h00021, 0, 0, 16'h0,    "R3", "R7");
    issue(20'h00020, 1, 0, 16'h0,    "R4", "R4");
    issue(20'h00031, 1, 0, 16'h0,    "R5", "R8");
    issue(20'hFFFFF, 1, 0, 16'h0,    "R6", "R6");
    issue(20'h12345, 1, 0, 16'h0,    "R5", "R8");
    issue(20'h00000, 0, 0, 16'h0,    "R6", "R6");

    repeat (3) @(negedge clk);
    chk(bus_q.size() == 0, "R10", "bus queue drained", bus_q.size(), 32'h0);
    summary();
  end
endmodule